// File: doc/BRIEF.md
# Sync-Triggered Ramp Delay Down-Counter

This block holds back the start of a comparator ramp for a programmable number of clocks after each PWM period sync. Software writes a start count into a shadow register. The shadow register never drives the countdown directly. A rising edge on the sync input copies the shadow value into an active counter. The active counter then drops by one on every clock until it reaches zero, and it stays at zero until the next rising sync edge.

The active count and the shadow value are both visible on output ports. A zero flag follows the active count without a register stage, so downstream ramp logic can start in the same cycle the count reaches zero. A write to the shadow register changes only the value that the next sync edge will load. A countdown already running is not affected.

Top module: `ramp_delay_counter`

## Requirements
- R1: An active-low asynchronous reset clears the shadow register, the active count and the stored sync history to zero, and the zero flag reads 1 while reset is held.
- R2: A clock edge with `shadow_we` high stores `shadow_wdata` into the shadow register, and `shadow_q` shows the stored value after that edge.
- R3: A rising sync edge is a clock edge where `sync_in` is 1 and `sync_in` was 0 at the previous edge. At that edge the active count takes the shadow value held before the edge. A shadow write in the same cycle lands only in the shadow register.
- R4: On every edge that is not a rising sync edge, a nonzero active count drops by exactly one.
- R5: Once the active count is zero it stays at zero, without wrapping, until the next rising sync edge.
- R6: If `sync_in` is held high for many cycles, the counter reloads only once.
- R7: A rising sync edge that arrives while the count is still nonzero restarts the count from the shadow value.
- R8: Shadow writes never change the active count. A countdown in progress continues unchanged.
- R9: `at_zero` is 1 exactly when the active count is zero, in the same cycle, with no register stage.
- R10: A shadow value of zero loads as zero and sets the flag at once. The all-ones shadow value counts down through every value to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_in | input | 1 | PWM period sync; its rising edge reloads the counter |
| shadow_we | input | 1 | Write strobe for the shadow register |
| shadow_wdata | input | WIDTH | Start count to store in the shadow register |
| shadow_q | output | WIDTH | Shadow register read-back |
| count_q | output | WIDTH | Active count read-back |
| at_zero | output | 1 | High while the active count is zero |

## Verification
A shadow write and a rising sync edge can arrive in the same clock. The bench raises `shadow_we` with a new value together with `sync_in` after a low cycle. It then requires the active count to hold the previous shadow value, the shadow read-back to show the new value, and a later sync pulse to load the new value. A second overlap is a reload against a countdown that is still running. The bench checks it with the R7 restart test and with shadow writes issued during a countdown, comparing each cycle against the value of the last load minus the elapsed clocks, floored at zero.

// File: rtl/ramp_delay_counter.sv
module ramp_delay_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             shadow_we,
  input  logic [WIDTH-1:0] shadow_wdata,
  output logic [WIDTH-1:0] shadow_q,
  output logic [WIDTH-1:0] count_q,
  output logic             at_zero
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             sync_q;
  logic             reload;
  logic [WIDTH-1:0] shadow_r;
  logic [WIDTH-1:0] count_r;
  logic [WIDTH-1:0] count_nxt;

  assign reload  = sync_in & ~sync_q;
  assign at_zero = (count_r == ZERO);

  always_comb begin
    if (reload)       count_nxt = shadow_r;
    else if (at_zero) count_nxt = ZERO;
    else              count_nxt = count_r - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      shadow_r <= ZERO;
      count_r  <= ZERO;
    end else begin
      sync_q  <= sync_in;
      count_r <= count_nxt;
      if (shadow_we) shadow_r <= shadow_wdata;
    end
  end

  assign shadow_q = shadow_r;
  assign count_q  = count_r;

endmodule

module ramp_delay_counter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_in,
  input logic             sync_q,
  input logic             shadow_we,
  input logic [WIDTH-1:0] shadow_wdata,
  input logic [WIDTH-1:0] shadow_q,
  input logic [WIDTH-1:0] count_q,
  input logic             at_zero
);

  logic edge_seen;
  assign edge_seen = sync_in && !sync_q;

  a_r2_shadow_write: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_we |=> shadow_q == $past(shadow_wdata));

  a_r3_load_old_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> count_q == $past(shadow_q));

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_seen && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

  a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_seen && count_q == '0) |=> count_q == '0);

  a_r9_flag_leaves_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(at_zero) |-> $past(edge_seen));

  a_r9_flag_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(at_zero) |-> $past(count_q) == 1 || $past(edge_seen));

endmodule

bind ramp_delay_counter ramp_delay_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_q(sync_q),
  .shadow_we(shadow_we), .shadow_wdata(shadow_wdata),
  .shadow_q(shadow_q), .count_q(count_q), .at_zero(at_zero)
);

// File: tb/tb_ramp_delay_counter.sv
module tb_ramp_delay_counter;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sync_in = 1'b0;
  logic         shadow_we = 1'b0;
  logic [W-1:0] shadow_wdata = '0;
  logic [W-1:0] shadow_q;
  logic [W-1:0] count_q;
  logic         at_zero;

  int checks = 0;
  int errors = 0;

  ramp_delay_counter #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
    .shadow_we(shadow_we), .shadow_wdata(shadow_wdata),
    .shadow_q(shadow_q), .count_q(count_q), .at_zero(at_zero)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int v);
    shadow_we = 1'b1; shadow_wdata = W'(v);
    step();
    shadow_we = 1'b0;
  endtask

  task automatic pulse();
    sync_in = 1'b1;
    step();
    sync_in = 1'b0;
  endtask

  function automatic int floor0(input int v);
    return (v < 0) ? 0 : v;
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #15;
    chk("R1 count in reset", count_q, 0);
    chk("R1 shadow in reset", shadow_q, 0);
    chk("R1 flag in reset", at_zero, 1);
    #20 rst_n = 1'b1;
    step();

    wr(5);
    chk("R2 shadow readback", shadow_q, 5);
    chk("R8 write leaves count", count_q, 0);

    pulse();
    chk("R3 load", count_q, 5);
    for (int n = 1; n <= 8; n++) begin
      step();
      chk("R4/R5 countdown", count_q, floor0(5 - n));
      chk("R9 flag", at_zero, (floor0(5 - n) == 0) ? 1 : 0);
    end

    for (int s = 0; s <= 20; s++) begin
      wr(s);
      pulse();
      chk("R3/R10 sweep load", count_q, s);
      chk("R9/R10 sweep flag", at_zero, (s == 0) ? 1 : 0);
      for (int n = 1; n <= s + 2; n++) begin
        step();
        chk("R4/R5 sweep count", count_q, floor0(s - n));
        chk("R9 sweep flag", at_zero, (s - n <= 0) ? 1 : 0);
      end
    end

    wr(3);
    sync_in = 1'b1;
    step();
    chk("R6 first load", count_q, 3);
    for (int n = 1; n <= 6; n++) begin
      step();
      chk("R6 held sync no reload", count_q, floor0(3 - n));
    end
    sync_in = 1'b0;
    step();

    wr(10);
    pulse();
    for (int n = 0; n < 4; n++) step();
    chk("R7 mid count", count_q, 6);
    pulse();
    chk("R7 restart", count_q, 10);

    wr(2);
    chk("R8 count after write", count_q, 9);
    chk("R2 shadow after write", shadow_q, 2);
    step();
    chk("R8 countdown undisturbed", count_q, 8);

    shadow_we = 1'b1; shadow_wdata = W'(7); sync_in = 1'b1;
    step();
    shadow_we = 1'b0; sync_in = 1'b0;
    chk("R3 same-cycle write loads old", count_q, 2);
    chk("R3 same-cycle write stored", shadow_q, 7);
    step();
    pulse();
    chk("R3 next edge loads new", count_q, 7);

    wr(65535);
    pulse();
    chk("R10 max load", count_q, 65535);
    step();
    chk("R10 max first step", count_q, 65534);
    for (int n = 2; n < 65535; n++) step();
    chk("R10 max one left", count_q, 1);
    chk("R9 max flag low", at_zero, 0);
    step();
    chk("R10 max reaches zero", count_q, 0);
    chk("R9 max flag high", at_zero, 1);
    step();
    chk("R5 no wrap", count_q, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule